// File: doc/BRIEF.md
# Short Preamble and Header Bit Generator

This block produces the serial bit stream that opens a short-format high-rate packet: a run of scrambled sync bits, a 16-bit start delimiter, and a 48-bit header. The header holds an 8-bit signal value, an 8-bit service value, a 16-bit length value and a 16-bit check code. A controller presents the three header values with a one-cycle start strobe. The block then emits exactly one scrambled bit on each enable tick from the downstream modulator. A flag goes with each bit and tells whether it belongs to the 1 Mbps preamble part or the 2 Mbps header part.

After the last check-code bit, the block raises a one-cycle done pulse so the payload path can take over. The scrambler is self-synchronizing and runs through the whole stream without a break. The check code is computed only over the signal, service and length bits.

Top module: `shpre_hdr_gen`

## Requirements
- R1: After reset, bit_vld_o, bit_o, rate_hi_o, busy_o and done_o are all 0.
- R2: A start_i pulse while busy_o is 0 latches sig_i, svc_i and len_i and sets busy_o in the next cycle. While idle, bit_en_i produces no output bit.
- R3: Each bit_en_i cycle while busy produces exactly one bit, with bit_vld_o high in the following cycle. A frame is exactly 120 bits.
- R4: Before scrambling, stream bits 0 to 55 are zero.
- R5: Before scrambling, stream bits 56 to 71 are the delimiter 16'h05CF, sent bit 0 first (1,1,1,1,0,0,1,1,1,0,1,0,0,0,0,0).
- R6: Before scrambling, stream bits 72 to 103 are the signal, service and length fields in that order, each sent least significant bit first.
- R7: Before scrambling, stream bits 104 to 119 are the ones-complement of a CRC over stream bits 72 to 103, sent bit 15 first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), starts from 16'hFFFF and is updated with fb = d ^ crc[15], crc = (crc<<1) ^ (fb ? 0x1021 : 0).
- R8: Every output bit is d ^ s[3] ^ s[6], where s is a 7-bit register loaded with parameter SCR_SEED on an accepted start. After each bit, s becomes {s[5:0], output bit}. s carries over across the preamble/header boundary.
- R9: rate_hi_o is 0 for stream bits 0 to 71 (1 Mbps part) and 1 for bits 72 to 119 (2 Mbps part). It is sampled together with bit_o.
- R10: done_o is high for exactly one cycle, in the cycle after the one where bit_vld_o shows bit 119. busy_o is 0 in that done cycle.
- R11: A start_i pulse while busy_o is 1 is ignored: the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new frame |
| sig_i | input | 8 | Signal field value |
| svc_i | input | 8 | Service field value |
| len_i | input | 16 | Length field value |
| bit_en_i | input | 1 | Bit enable tick from the modulator |
| bit_o | output | 1 | Scrambled output bit |
| bit_vld_o | output | 1 | bit_o carries a new bit this cycle |
| rate_hi_o | output | 1 | 0 = 1 Mbps preamble bit, 1 = 2 Mbps header bit |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last header bit |

## Verification
Two events can land in one cycle. A start strobe can coincide with the enable tick, either in mid-frame or on the final bit. A new start can also arrive in the same cycle as the done pulse. The bench raises start_i with different field values partway through a frame and expects the complete original 120-bit stream. It also issues the next start in the exact cycle done_o is seen, and expects that second frame to be accepted and emitted correctly from its first bit. Enable patterns of every cycle, every third cycle and an irregular spacing make sure the output timing does not depend on tick spacing.

// File: rtl/shpre_pkg.sv
package shpre_pkg;

    localparam int SIG_W     = 8;
    localparam int SVC_W     = 8;
    localparam int LEN_W     = 16;
    localparam int CRC_W     = 16;
    localparam int FLD_W     = SIG_W + SVC_W + LEN_W;
    localparam int SCR_W     = 7;
    localparam int SCR_TAP_A = 4;
    localparam int SCR_TAP_B = 7;

    localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

    // Header values; sig sits at the low end so bit 0 is sent first
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [SVC_W-1:0] svc;
        logic [SIG_W-1:0] sig;
    } hdr_fields_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_DLM  = 2'd1,
        PH_FLD  = 2'd2,
        PH_CRC  = 2'd3
    } phase_e;

    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                  input logic d);
        logic fb;
        fb = d ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic scr_out(input logic [SCR_W-1:0] s, input logic d);
        return d ^ s[SCR_TAP_A-1] ^ s[SCR_TAP_B-1];
    endfunction

endpackage

// File: rtl/shpre_scr.sv
module shpre_scr
    import shpre_pkg::*;
#(
    parameter logic [SCR_W-1:0] SEED = 7'h6C
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    input  logic din,
    output logic dout
);

    logic [SCR_W-1:0] st_q;

    always_comb dout = scr_out(st_q, din);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= SEED;
        end else if (adv) begin
            st_q <= {st_q[SCR_W-2:0], dout};
        end
    end

    // Scrambler state only moves when loaded or stepped
    assert_scr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(st_q));

endmodule

// File: rtl/shpre_crc16.sv
module shpre_crc16
    import shpre_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic upd,
    input  logic shift,
    input  logic din,
    output logic msb
);

    logic [CRC_W-1:0] crc_q;

    always_comb msb = crc_q[CRC_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (init) begin
            crc_q <= CRC_PRESET;
        end else if (upd) begin
            crc_q <= crc_next(crc_q, din);
        end else if (shift) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assert_crc_preset_R7: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc_q == CRC_PRESET));

    assert_crc_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(upd && shift));

endmodule

// File: rtl/shpre_seq.sv
module shpre_seq
    import shpre_pkg::*;
#(
    parameter int                  SYNC_LEN = 56,
    parameter int                  DLM_LEN  = 16,
    parameter logic [DLM_LEN-1:0]  DLM_PAT  = 16'h05CF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        tick,
    input  hdr_fields_t fields,
    output phase_e      phase,
    output logic        pre_bit,
    output logic        last
);

    localparam int TOTAL  = SYNC_LEN + DLM_LEN + FLD_W + CRC_W;
    localparam int IDX_W  = $clog2(TOTAL);
    localparam int DLM_IW = $clog2(DLM_LEN);
    localparam int FLD_IW = $clog2(FLD_W);
    localparam logic [IDX_W-1:0] END_DLM = IDX_W'(SYNC_LEN + DLM_LEN);
    localparam logic [IDX_W-1:0] END_FLD = IDX_W'(SYNC_LEN + DLM_LEN + FLD_W);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(TOTAL - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] dlm_off;
    logic [IDX_W-1:0] fld_off;
    logic [FLD_W-1:0] fld_vec;

    always_comb begin
        dlm_off = idx_q - IDX_W'(SYNC_LEN);
        fld_off = idx_q - END_DLM;
        fld_vec = fields;
        last    = (idx_q == LAST_IX);
        if (idx_q < IDX_W'(SYNC_LEN)) begin
            phase   = PH_SYNC;
            pre_bit = 1'b0;
        end else if (idx_q < END_DLM) begin
            phase   = PH_DLM;
            pre_bit = DLM_PAT[dlm_off[DLM_IW-1:0]];
        end else if (idx_q < END_FLD) begin
            phase   = PH_FLD;
            pre_bit = fld_vec[fld_off[FLD_IW-1:0]];
        end else begin
            phase   = PH_CRC;
            pre_bit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx_q <= '0;
        end else if (tick && !last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IX);

    assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(idx_q));

endmodule

// File: rtl/shpre_hdr_gen.sv
module shpre_hdr_gen
    import shpre_pkg::*;
#(
    parameter int                 SYNC_LEN = 56,
    parameter int                 DLM_LEN  = 16,
    parameter logic [DLM_LEN-1:0] DLM_PAT  = 16'h05CF,
    parameter logic [SCR_W-1:0]   SCR_SEED = 7'h6C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [SVC_W-1:0] svc_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             bit_en_i,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             rate_hi_o,
    output logic             busy_o,
    output logic             done_o
);

    hdr_fields_t fields_q;
    phase_e      phase;
    logic        busy_q;
    logic        fin_q;
    logic        accept;
    logic        tick;
    logic        pre_bit;
    logic        last;
    logic        crc_msb;
    logic        raw_bit;
    logic        scr_bit;

    always_comb begin
        accept  = start_i && !busy_q;
        tick    = bit_en_i && busy_q;
        raw_bit = (phase == PH_CRC) ? ~crc_msb : pre_bit;
    end

    shpre_seq #(
        .SYNC_LEN (SYNC_LEN),
        .DLM_LEN  (DLM_LEN),
        .DLM_PAT  (DLM_PAT)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick),
        .fields  (fields_q),
        .phase   (phase),
        .pre_bit (pre_bit),
        .last    (last)
    );

    shpre_crc16 crc_i (
        .clk   (clk),
        .rst   (rst),
        .init  (accept),
        .upd   (tick && (phase == PH_FLD)),
        .shift (tick && (phase == PH_CRC)),
        .din   (raw_bit),
        .msb   (crc_msb)
    );

    shpre_scr #(
        .SEED (SCR_SEED)
    ) scr_i (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .adv  (tick),
        .din  (raw_bit),
        .dout (scr_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q  <= '0;
            busy_q    <= 1'b0;
            fin_q     <= 1'b0;
            done_o    <= 1'b0;
            bit_o     <= 1'b0;
            bit_vld_o <= 1'b0;
            rate_hi_o <= 1'b0;
        end else begin
            if (accept) begin
                fields_q <= '{len: len_i, svc: svc_i, sig: sig_i};
                busy_q   <= 1'b1;
            end else if (tick && last) begin
                busy_q <= 1'b0;
            end
            fin_q     <= tick && last;
            done_o    <= fin_q;
            bit_vld_o <= tick;
            if (tick) begin
                bit_o     <= scr_bit;
                rate_hi_o <= (phase == PH_FLD) || (phase == PH_CRC);
            end
        end
    end

    always_comb busy_o = busy_q;

    assert_sync_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && phase == PH_SYNC) |-> !raw_bit);

    assert_vld_from_tick_R3: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> $past(bit_en_i && busy_o));

    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !$past(done_o) && $past(bit_vld_o)));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !bit_en_i) |=> busy_o);

    assert_rate_low_sync_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bit_en_i && phase == PH_SYNC) |=> !rate_hi_o);

endmodule

// File: tb/shpre_hdr_gen_tb_top.sv
`timescale 1ns/1ps
module shpre_hdr_gen_tb_top;

    localparam int         NBITS = 120;
    localparam logic [6:0] SEED  = 7'h6C;
    localparam logic [15:0] DLM  = 16'h05CF;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [7:0]  sig_i;
    logic [7:0]  svc_i;
    logic [15:0] len_i;
    logic        bit_en_i;
    logic        bit_o, bit_vld_o, rate_hi_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit chain_req = 0;
    logic [7:0]  nx_sig, nx_svc;
    logic [15:0] nx_len;

    logic exp_bit [NBITS];
    logic exp_rate[NBITS];

    always #4 clk = ~clk;

    shpre_hdr_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .sig_i     (sig_i),
        .svc_i     (svc_i),
        .len_i     (len_i),
        .bit_en_i  (bit_en_i),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o),
        .rate_hi_o (rate_hi_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected stream from the requirements (R4..R9)
    task automatic build(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l);
        logic        raw[NBITS];
        logic [31:0] h;
        logic [15:0] c;
        logic [6:0]  st;
        logic        fb, o;
        h = {l, v, s};
        c = 16'hFFFF;
        for (int i = 0; i < 56; i++) raw[i] = 1'b0;
        for (int i = 0; i < 16; i++) raw[56 + i] = DLM[i];
        for (int i = 0; i < 32; i++) begin
            raw[72 + i] = h[i];
            fb = h[i] ^ c[15];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        for (int i = 0; i < 16; i++) raw[104 + i] = ~c[15 - i];
        st = SEED;
        for (int i = 0; i < NBITS; i++) begin
            o = raw[i] ^ st[3] ^ st[6];
            st = {st[5:0], o};
            exp_bit[i]  = o;
            exp_rate[i] = (i >= 72);
        end
    endtask

    function automatic logic tick_pat(input int mode, input int cyc);
        case (mode)
            0:       return 1'b1;
            1:       return (cyc % 3) == 0;
            default: return ((cyc * 5) % 7) < 3;
        endcase
    endfunction

    task automatic run_frame(input logic [7:0] s, input logic [7:0] v, input logic [15:0] l,
                             input int mode, input bit poke, input bit pre);
        int  k = 0;
        int  last_v = -10;
        bit  seen_done = 0;
        bit  poked = 0;
        bit  chained = 0;
        build(s, v, l);
        if (!pre) begin
            @(negedge clk);
            start_i = 1'b1; sig_i = s; svc_i = v; len_i = l;
        end
        @(negedge clk);
        start_i = 1'b0;
        bit_en_i = 1'b0;
        chk(busy_o == 1'b1, "R2", busy_o, 1, "busy after start");
        for (int cyc = 0; cyc < 4000 && !seen_done; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (bit_vld_o) begin
                if (k < NBITS) begin
                    if (k < 56)       chk(bit_o == exp_bit[k], "R4", bit_o, exp_bit[k], "sync bit");
                    else if (k < 72)  chk(bit_o == exp_bit[k], "R5", bit_o, exp_bit[k], "delimiter bit");
                    else if (k < 104) chk(bit_o == exp_bit[k], "R6", bit_o, exp_bit[k], "field bit");
                    else              chk(bit_o == exp_bit[k], "R7", bit_o, exp_bit[k], "crc bit");
                    chk(rate_hi_o == exp_rate[k], "R9", rate_hi_o, exp_rate[k], "rate flag");
                end else begin
                    chk(1'b0, "R3", k, NBITS - 1, "extra bit");
                end
                last_v = cyc;
                k++;
            end
            if (done_o) begin
                seen_done = 1;
                chk(k == NBITS, "R3", k, NBITS, "bit count");
                chk(last_v == cyc - 1, "R10", cyc - last_v, 1, "done timing");
                chk(busy_o == 1'b0, "R10", busy_o, 0, "busy at done");
                if (chain_req) begin
                    start_i = 1'b1; sig_i = nx_sig; svc_i = nx_svc; len_i = nx_len;
                    chain_req = 0;
                    chained = 1;
                end
            end
            if (poke && !poked && k == 40) begin
                poked = 1;
                start_i = 1'b1; sig_i = ~s; svc_i = ~v; len_i = ~l;  // R11 mid-frame start
            end
            bit_en_i = tick_pat(mode, cyc);
        end
        bit_en_i = 1'b0;
        chk(seen_done, "R10", seen_done, 1, "done seen");
        if (!chained) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R10", done_o, 0, "done width");
            chk(bit_vld_o == 1'b0, "R3", bit_vld_o, 0, "no bit after frame");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; bit_en_i = 1'b0;
        sig_i = '0; svc_i = '0; len_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({bit_vld_o, bit_o, rate_hi_o, busy_o, done_o} == 5'b0, "R1",
            {bit_vld_o, bit_o, rate_hi_o, busy_o, done_o}, 0, "reset outputs");
        // Idle ticks produce nothing (R2)
        bit_en_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(bit_vld_o == 1'b0, "R2", bit_vld_o, 0, "idle tick");
        end
        bit_en_i = 1'b0;

        run_frame(8'h00, 8'h00, 16'h0000, 0, 0, 0);
        run_frame(8'hFF, 8'hFF, 16'hFFFF, 1, 0, 0);
        run_frame(8'h0A, 8'h04, 16'h1234, 2, 0, 0);
        // R11: start during a frame, with R8 seed reload avoided
        run_frame(8'h6E, 8'h84, 16'h0100, 0, 1, 0);
        // Start in the done cycle
        nx_sig = 8'h37; nx_svc = 8'hC3; nx_len = 16'hBEEF;
        chain_req = 1;
        run_frame(8'h14, 8'h00, 16'h00A0, 1, 0, 0);
        run_frame(8'h37, 8'hC3, 16'hBEEF, 0, 0, 1);
        // Sweep of signal values and tick patterns (R6, R7, R8)
        for (int i = 0; i < 8; i++) begin
            run_frame(8'(i * 37 + 1), 8'(1 << i), 16'(i * 4099), i % 3, 0, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule